// File: doc/BRIEF.md
# Run-Time Configurable Sum-of-Products Array

This block evaluates a set of Boolean functions written as sums of products over a small vector of input variables. It is built from two planes. In the literal plane, each product term picks, for each input variable, one of three choices: the true literal, the complemented literal, or no dependence on that variable. In the connection plane, each output function ORs together any subset of the product terms. A single product term can feed any number of outputs. Because of that, the number of terms is a parameter of its own and does not follow from the number of outputs.

Both planes are stored in one configuration shift chain that is loaded serially at run time. Software or a controller shifts in the full image, one bit per clock. It then pulses a done strobe, which marks the configuration valid. Until that happens, every output is held low. Starting a new load drops the valid flag again, so partly loaded planes never reach the outputs.

Top module: `pla_core`

## Requirements
- R1: The literal cell for term t and variable i sits at chain bits [2*(t*N_IN+i)+1 : 2*(t*N_IN+i)]. Code 2'b01 places the true variable in the term, 2'b10 places the complemented variable, and 2'b00 leaves the variable out of the term.
- R2: A literal cell holding code 2'b11 forces its product term to 0 for every input value.
- R3: Connection bit 2*N_IN*N_TERM + o*N_TERM + t set to 1 ORs term t into output o, and set to 0 leaves it out. One term may drive several outputs at once.
- R4: An output with no connected term is 0. A term whose cells are all absent is 1, so any output it connects to is 1.
- R5: While cfg_en_i is high, the chain shifts one position toward higher indices on each clock, and cfg_bit_i enters at index 0. After a full load, the first bit shifted in lands at the top index.
- R6: While cfg_en_i is low, the chain keeps its contents and cfg_bit_i has no effect on the outputs.
- R7: While the valid flag is low, all outputs are 0. A cfg_done_i pulse with cfg_en_i low sets the flag on the next clock. Any clock with cfg_en_i high clears it.
- R8: Reset clears both planes and the valid flag. After reset, a done pulse without a load gives all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_bit_i | input | 1 | Serial configuration data |
| cfg_done_i | input | 1 | Marks the loaded configuration valid |
| vars_i | input | N_IN | Logic variables, bit 0 = first variable |
| func_o | output | N_OUT | Evaluated functions, zero while not valid |
| cfg_valid_o | output | 1 | Configuration valid flag |

## Verification
The assertions assume that cfg_en_i and cfg_done_i are never both high when a new configuration is meant to take effect. They also assume that vars_i is known whenever the flag is set. The stimulus drops cfg_en_i for at least one clock before it pulses cfg_done_i, and it changes vars_i only on the falling edge. The assertions also assume that code 2'b11 appears only in cells that are meant to suppress a term. The bench writes that code only in the one test that exercises it.

// File: rtl/pla_pkg.sv
package pla_pkg;
  typedef enum logic [1:0] {
    LIT_NONE = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;

  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    case (lit_e'(code))
      LIT_NONE: lit_pass = 1'b1;
      LIT_POS:  lit_pass = x;
      LIT_NEG:  lit_pass = ~x;
      default:  lit_pass = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int unsigned TOT = 50
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_en_i,
  input  logic           cfg_bit_i,
  input  logic           cfg_done_i,
  output logic [TOT-1:0] chain_o,
  output logic           valid_o
);
  logic [TOT-1:0] chain_q;
  logic           valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cfg_en_i) chain_q <= {chain_q[TOT-2:0], cfg_bit_i};
      // a load in progress always wins over done
      if (cfg_en_i)        valid_q <= 1'b0;
      else if (cfg_done_i) valid_q <= 1'b1;
    end
  end

  assign chain_o = chain_q;
  assign valid_o = valid_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> chain_q[0] == $past(cfg_bit_i)); // R5
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> chain_q[TOT-1:1] == $past(chain_q[TOT-2:0])); // R5
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(chain_q)); // R6
  AST_VALID_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && !cfg_en_i) |=> valid_q); // R7
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !valid_q); // R7
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 5,
  localparam int unsigned AW    = 2 * N_IN * N_TERM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     and_cfg_i,
  input  logic [N_IN-1:0]   vars_i,
  output logic [N_TERM-1:0] term_o
);
  logic [N_TERM*N_IN-1:0] cell_ok;
  logic [N_TERM*N_IN-1:0] cell_kill;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    for (genvar i = 0; i < N_IN; i++) begin : g_cell
      assign cell_ok[t*N_IN+i]   = pla_pkg::lit_pass(and_cfg_i[2*(t*N_IN+i) +: 2], vars_i[i]);
      assign cell_kill[t*N_IN+i] = &and_cfg_i[2*(t*N_IN+i) +: 2];
    end
    assign term_o[t] = &cell_ok[t*N_IN +: N_IN];

    AST_KILL_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cell_kill[t*N_IN +: N_IN]) |-> !term_o[t]); // R2
    AST_ALL_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (and_cfg_i[2*t*N_IN +: 2*N_IN] == '0) |-> term_o[t]); // R4
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 5,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned OW    = N_TERM * N_OUT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     or_cfg_i,
  input  logic [N_TERM-1:0] term_i,
  input  logic              valid_i,
  output logic [N_OUT-1:0]  func_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign func_o[o] = valid_i & |(term_i & or_cfg_i[o*N_TERM +: N_TERM]);

    AST_EMPTY_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (or_cfg_i[o*N_TERM +: N_TERM] == '0) |-> !func_o[o]); // R4
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned N_TERM = 5,
  parameter int unsigned N_OUT  = 4,
  localparam int unsigned AW    = 2 * N_IN * N_TERM,
  localparam int unsigned OW    = N_TERM * N_OUT,
  localparam int unsigned TOT   = AW + OW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic             cfg_done_i,
  input  logic [N_IN-1:0]  vars_i,
  output logic [N_OUT-1:0] func_o,
  output logic             cfg_valid_o
);
  logic [TOT-1:0]    chain;
  logic [N_TERM-1:0] term;
  logic              valid;

  pla_cfg_chain #(.TOT(TOT)) u_chain (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_bit_i, .cfg_done_i,
    .chain_o(chain), .valid_o(valid)
  );

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk_i, .rst_ni, .and_cfg_i(chain[AW-1:0]), .vars_i, .term_o(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk_i, .rst_ni, .or_cfg_i(chain[TOT-1:AW]), .term_i(term),
    .valid_i(valid), .func_o
  );

  assign cfg_valid_o = valid;

  AST_OUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_o |-> (func_o == '0)); // R7
  AST_LOAD_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> (func_o == '0)); // R7
endmodule

// File: tb/sim_pla_core.sv
module sim_pla_core;
  localparam int NI = 3, NT = 5, NO = 4;
  localparam int AW = 2*NI*NT, TOT = AW + NT*NO;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_bit = 0, cfg_done = 0;
  logic [NI-1:0] vars = '0;
  logic [NO-1:0] func;
  logic valid;
  logic [TOT-1:0] cfg_v;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .cfg_done_i(cfg_done), .vars_i(vars), .func_o(func), .cfg_valid_o(valid)
  );

  // {vars = C,B,A ; expected = F3,F2,F1,F0} for the reference image
  localparam logic [6:0] TBL [8] = '{
    {3'b000, 4'b0101}, {3'b100, 4'b1000}, {3'b010, 4'b0000}, {3'b110, 4'b0000},
    {3'b001, 4'b1111}, {3'b101, 4'b1001}, {3'b011, 4'b1111}, {3'b111, 4'b1111}
  };

  task automatic chk(input logic [NO-1:0] act, input logic [NO-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_lit(input int t, input int i, input logic [1:0] code);
    cfg_v[2*(t*NI+i) +: 2] = code;
  endtask

  task automatic set_con(input int t, input int o);
    cfg_v[AW + o*NT + t] = 1'b1;
  endtask

  task automatic load_and_commit();
    for (int k = TOT-1; k >= 0; k--) begin
      @(negedge clk); cfg_en = 1; cfg_bit = cfg_v[k];
    end
    @(negedge clk); cfg_en = 0; cfg_bit = 0;
    @(negedge clk); cfg_done = 1;
    @(negedge clk); cfg_done = 0;
    #1;
  endtask

  task automatic apply(input logic [NI-1:0] v);
    @(negedge clk); vars = v; #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8*200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(func, '0, "R8 reset outputs");
    chk({3'b0, valid}, 4'b0, "R8 reset valid");
    rst_n = 1;

    // done without load: cleared planes give zeros
    @(negedge clk); cfg_done = 1; vars = 3'b111;
    @(negedge clk); cfg_done = 0; #1;
    chk({3'b0, valid}, 4'b1, "R7 done sets valid");
    chk(func, '0, "R8 cleared planes drive 0 (R4 no terms)");

    // reference image: T0=AB T1=B'C T2=AC' T3=B'C' T4=A
    cfg_v = '0;
    set_lit(0,0,2'b01); set_lit(0,1,2'b01);
    set_lit(1,1,2'b10); set_lit(1,2,2'b01);
    set_lit(2,0,2'b01); set_lit(2,2,2'b10);
    set_lit(3,1,2'b10); set_lit(3,2,2'b10);
    set_lit(4,0,2'b01);
    set_con(4,0); set_con(3,0);
    set_con(2,1); set_con(0,1);
    set_con(3,2); set_con(0,2);
    set_con(1,3); set_con(4,3);

    // partial load: valid drops, outputs held low
    @(negedge clk); cfg_en = 1; cfg_bit = cfg_v[TOT-1];
    @(negedge clk); #1;
    chk(func, '0, "R7 outputs zero during load");
    cfg_en = 0;

    load_and_commit();
    chk({3'b0, valid}, 4'b1, "R7 valid after commit");
    for (int n = 0; n < 8; n++) begin
      apply(TBL[n][6:4]);
      chk(func, TBL[n][3:0], "R1 R3 R5 reference table");
    end

    // R6: serial input toggles with enable low
    apply(3'b101);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); cfg_bit = ~cfg_bit;
    end
    #1;
    chk(func, 4'b1001, "R6 config held with enable low");
    apply(3'b000);
    chk(func, 4'b0101, "R6 config held second vector");

    // R2: forced-zero cell versus absent cell
    cfg_v = '0;
    set_lit(0,0,2'b01); set_lit(0,1,2'b01); set_lit(0,2,2'b11);
    set_con(0,0);
    load_and_commit();
    apply(3'b011);
    chk(func, 4'b0000, "R2 kill code forces term 0");
    apply(3'b111);
    chk(func, 4'b0000, "R2 kill code any input");
    cfg_v[2*2 +: 2] = 2'b00;
    load_and_commit();
    apply(3'b011);
    chk(func, 4'b0001, "R1 absent variable ignored");

    // R4: all-absent term connected to F1 and F3 only
    cfg_v = '0;
    set_con(2,1); set_con(2,3);
    load_and_commit();
    apply(3'b000);
    chk(func, 4'b1010, "R4 all-absent term shared");
    apply(3'b110);
    chk(func, 4'b1010, "R4 all-absent term other input");

    // R7: one enable cycle clears valid
    @(negedge clk); cfg_en = 1;
    @(negedge clk); cfg_en = 0; #1;
    chk({3'b0, valid}, 4'b0, "R7 enable clears valid");
    chk(func, 4'b0000, "R7 outputs gated");

    // R8: reset mid-operation clears planes
    load_and_commit();
    @(negedge clk); rst_n = 0; #1;
    chk(func, 4'b0000, "R8 reset gates outputs");
    @(negedge clk); rst_n = 1;
    @(negedge clk); cfg_done = 1;
    @(negedge clk); cfg_done = 0; #1;
    chk(func, 4'b0000, "R8 planes cleared after reset");

    finish_run();
  end
endmodule